// File: doc/BRIEF.md
# D-PHY Receiver Bring-Up Sequencer

This block powers a D-PHY receiver up and down in a fixed order. A start command captures a line rate in Mbps and an active-lane count, and the block then runs the whole power-up sequence by itself. It writes the lane setting and holds the PHY in shutdown and reset. It pulses the test-clear line, then looks up the high-speed frequency-range code for the captured rate. It hands that code to an external test-port engine as one write request. Last, it releases shutdown, PHY reset and controller reset in that order, with a timed gap after each release.

All waits are counted in system clocks. A microsecond prescaler, sized by a clocks-per-microsecond parameter, drives them. The test-port engine is outside the block. The block holds a request with a fixed test code and a data byte, and it waits until the engine signals completion. A stop command puts the lane setting back to a single lane and holds the controller in reset. Start and stop are accepted only while no sequence is running.

Top module: `dphy_rx_bringup`

## Requirements
- R1: After reset, every output is low: the lane setting, shutdown, PHY reset, controller reset, test clock, test enable, test clear, request, busy, ready and the range error flag.
- R2: One clock after an accepted start, the lane setting equals the lane count minus one. Shutdown and PHY reset (both active low) are low, test clock is 1, test enable is 0, test clear is 1 and busy is 1.
- R3: Test clear stays high for at least T_CLR_US microseconds. The test-port request rises no sooner than T_SETTLE_US microseconds after test clear falls. Each wait is counted as CLKS_PER_US clocks per microsecond.
- R4: Exactly one test-port request is issued per start. Its test code is 0x44. Its data byte is {1'b0, code[5:0], 1'b0}, where code comes from the first upper limit in the ascending list that the captured rate does not exceed. The (limit: code) list is 89:0x00, 99:0x10, 109:0x20, 129:0x01, 139:0x11, 149:0x21, 169:0x02, 179:0x12, 199:0x22, 219:0x03, 239:0x13, 249:0x23, 269:0x04, 299:0x14, 329:0x05, 359:0x15, 399:0x25, 449:0x06, 499:0x16, 549:0x07, 599:0x17, 649:0x08, 699:0x18, 749:0x09, 799:0x19, 849:0x29, 899:0x39, 949:0x0A, 999:0x1A, 1049:0x2A, 1099:0x3A, 1149:0x0B, 1199:0x1B, 1249:0x2B, 1299:0x3B, 1349:0x0C, 1399:0x1C, 1449:0x2C, 1500:0x3C. A rate above 1500 uses 0x3C.
- R5: The request stays high, with stable data, until the clock in which done is sampled high, and it drops in the next cycle.
- R6: At least T_GAP_US microseconds after done, shutdown rises. At least T_GAP_US microseconds after that, PHY reset rises, and the controller reset goes to all ones in the same cycle. PHY reset is never high while shutdown is low.
- R7: Ready rises at least T_CTRL_US microseconds after the controller reset is released, and busy falls in the same cycle. While ready is high, the controller reset is all ones and PHY reset is high.
- R8: The range error flag is set by a start whose rate is below 80 or above 1500, and cleared by a start whose rate is inside that range. The sequence runs either way.
- R9: A stop accepted while idle sets the lane setting to 0 (one lane), the controller reset to 0 and ready to 0 in the next cycle. If start and stop arrive together, start wins.
- R10: Start and stop have no effect while busy is high. The lane setting and the completed sequence keep the values of the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the power-up sequence (taken when idle) |
| stop_i | input | 1 | Return to single lane and hold controller reset (taken when idle) |
| rate_mbps_i | input | RATE_W | Line rate in Mbps, captured at start |
| lanes_i | input | LANE_W | Active data lane count, captured at start |
| tp_req_o | output | 1 | Test-port write request to the external engine |
| tp_code_o | output | 8 | Test code of the request |
| tp_data_o | output | 8 | Test data of the request |
| tp_done_i | input | 1 | Engine completed the request |
| lane_cfg_o | output | LCFG_W | Lane setting: active lanes minus one |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| tst_clk_o | output | 1 | Test clock idle level |
| tst_en_o | output | 1 | Test enable idle level |
| tst_clr_o | output | 1 | Test clear |
| ctrl_rst_n_o | output | CTRL_W | Controller reset, active low, all ones when released |
| busy_o | output | 1 | A sequence is running |
| ready_o | output | 1 | A start has completed and no stop has followed |
| rate_err_o | output | 1 | Captured rate lies outside 80..1500 Mbps |

## Verification
The bench runs a full start sequence at both sides of every range limit: the limit itself and one above it. This tells an off-by-one comparison apart from a wrong table entry, and it shows the switch-over to the last code. Extra rates at 0, 79, 80, 1501 and the top of the rate field separate the error-flag bounds from the lookup bounds. The lane count cycles through every legal value, and the engine latency varies from zero to three cycles, which separates holding the request from a fixed one-cycle pulse. Some runs fire start and stop while busy, and stop commands are given between runs. Together these show whether commands are ignored mid-sequence and whether stop touches only the lane setting, the controller reset and ready.

// File: rtl/dphy_bringup_pkg.sv
// Package: shared sequencer state type and the rate-to-range table.
// Assumes rates fit in 16 bits; the table is ascending in its limit.
package dphy_bringup_pkg;

    localparam int N_RANGES = 39;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_SETTLE,
        ST_XFER,
        ST_SD_GAP,
        ST_RST_GAP,
        ST_CTRL_WAIT
    } seq_state_e;

    // Upper rate limit (Mbps, inclusive) of range slot idx.
    function automatic logic [15:0] range_limit(input int idx);
        case (idx)
            0:  range_limit = 16'd89;
            1:  range_limit = 16'd99;
            2:  range_limit = 16'd109;
            3:  range_limit = 16'd129;
            4:  range_limit = 16'd139;
            5:  range_limit = 16'd149;
            6:  range_limit = 16'd169;
            7:  range_limit = 16'd179;
            8:  range_limit = 16'd199;
            9:  range_limit = 16'd219;
            10: range_limit = 16'd239;
            11: range_limit = 16'd249;
            12: range_limit = 16'd269;
            13: range_limit = 16'd299;
            14: range_limit = 16'd329;
            15: range_limit = 16'd359;
            16: range_limit = 16'd399;
            17: range_limit = 16'd449;
            18: range_limit = 16'd499;
            19: range_limit = 16'd549;
            20: range_limit = 16'd599;
            21: range_limit = 16'd649;
            22: range_limit = 16'd699;
            23: range_limit = 16'd749;
            24: range_limit = 16'd799;
            25: range_limit = 16'd849;
            26: range_limit = 16'd899;
            27: range_limit = 16'd949;
            28: range_limit = 16'd999;
            29: range_limit = 16'd1049;
            30: range_limit = 16'd1099;
            31: range_limit = 16'd1149;
            32: range_limit = 16'd1199;
            33: range_limit = 16'd1249;
            34: range_limit = 16'd1299;
            35: range_limit = 16'd1349;
            36: range_limit = 16'd1399;
            37: range_limit = 16'd1449;
            default: range_limit = 16'd1500;
        endcase
    endfunction

    // Six-bit frequency-range code of range slot idx.
    function automatic logic [5:0] range_code(input int idx);
        case (idx)
            0:  range_code = 6'h00;
            1:  range_code = 6'h10;
            2:  range_code = 6'h20;
            3:  range_code = 6'h01;
            4:  range_code = 6'h11;
            5:  range_code = 6'h21;
            6:  range_code = 6'h02;
            7:  range_code = 6'h12;
            8:  range_code = 6'h22;
            9:  range_code = 6'h03;
            10: range_code = 6'h13;
            11: range_code = 6'h23;
            12: range_code = 6'h04;
            13: range_code = 6'h14;
            14: range_code = 6'h05;
            15: range_code = 6'h15;
            16: range_code = 6'h25;
            17: range_code = 6'h06;
            18: range_code = 6'h16;
            19: range_code = 6'h07;
            20: range_code = 6'h17;
            21: range_code = 6'h08;
            22: range_code = 6'h18;
            23: range_code = 6'h09;
            24: range_code = 6'h19;
            25: range_code = 6'h29;
            26: range_code = 6'h39;
            27: range_code = 6'h0A;
            28: range_code = 6'h1A;
            29: range_code = 6'h2A;
            30: range_code = 6'h3A;
            31: range_code = 6'h0B;
            32: range_code = 6'h1B;
            33: range_code = 6'h2B;
            34: range_code = 6'h3B;
            35: range_code = 6'h0C;
            36: range_code = 6'h1C;
            37: range_code = 6'h2C;
            default: range_code = 6'h3C;
        endcase
    endfunction

endpackage

// File: rtl/dphy_range_map.sv
// Range map: converts a line rate into the six-bit frequency-range code and
// flags rates outside the legal window. Purely combinational.
// Assumes RATE_W <= 16 and RATE_MIN <= RATE_MAX.
module dphy_range_map
    import dphy_bringup_pkg::*;
#(
    parameter int RATE_W   = 11,
    parameter int RATE_MIN = 80,
    parameter int RATE_MAX = 1500
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [5:0]        code_o,
    output logic              out_of_range_o
);

    localparam int LAST = N_RANGES - 1;

    logic [15:0]         rate_ext;
    logic [N_RANGES-1:0] fits;

    assign rate_ext = 16'(rate_i);

    // One comparator per slot: rate fits at or below this limit.
    for (genvar g = 0; g < N_RANGES; g++) begin : g_cmp
        assign fits[g] = (rate_ext <= range_limit(g));
    end

    // Pick the lowest fitting slot; rates past the list take the last slot.
    always_comb begin
        code_o = range_code(LAST);
        for (int i = LAST; i >= 0; i--) begin
            if (fits[i]) code_o = range_code(i);
        end
    end

    // Legal window check on the raw rate.
    always_comb begin
        out_of_range_o = (rate_ext < 16'(RATE_MIN)) || (rate_ext > 16'(RATE_MAX));
    end

endmodule

// File: rtl/dphy_us_timer.sv
// Microsecond wait timer: after a load of N microseconds it counts N ticks of
// a CLKS_PER_US prescaler and raises done for one clock. Assumes N >= 1.
// A new load restarts the timer.
module dphy_us_timer #(
    parameter int CLKS_PER_US = 100,
    parameter int US_W        = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] us_i,
    output logic            done_o
);

    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  left_q;
    logic             run_q;
    logic             tick;

    assign tick = run_q && (pre_q == PRE_LAST);

    // Prescaler: counts clocks within one microsecond while running.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i || tick || !run_q) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Microsecond countdown and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else if (load_i) begin
            left_q <= us_i;
            run_q  <= 1'b1;
            done_o <= 1'b0;
        end else if (tick) begin
            done_o <= (left_q == US_W'(1));
            run_q  <= (left_q != US_W'(1));
            left_q <= left_q - 1'b1;
        end else begin
            done_o <= 1'b0;
        end
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);

    p_idle_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_i) |=> !done_o);

endmodule

// File: rtl/dphy_rx_bringup.sv
// D-PHY receiver bring-up sequencer (top). It captures rate and lane count on
// start, then steps through test-clear, one test-port write of the range code,
// and ordered releases of shutdown, PHY reset and controller reset, each with
// a timed gap. Assumes an external engine answers each request with done.
module dphy_rx_bringup
    import dphy_bringup_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int RATE_W      = 11,
    parameter int LANE_W      = 3,
    parameter int LCFG_W      = 2,
    parameter int CTRL_W      = 8,
    parameter int T_CLR_US    = 15,
    parameter int T_SETTLE_US = 15,
    parameter int T_GAP_US    = 5,
    parameter int T_CTRL_US   = 10,
    parameter int RATE_MIN    = 80,
    parameter int RATE_MAX    = 1500,
    parameter logic [7:0] TEST_CODE = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic [LANE_W-1:0] lanes_i,
    output logic              tp_req_o,
    output logic [7:0]        tp_code_o,
    output logic [7:0]        tp_data_o,
    input  logic              tp_done_i,
    output logic [LCFG_W-1:0] lane_cfg_o,
    output logic              phy_shutdown_n_o,
    output logic              phy_rst_n_o,
    output logic              tst_clk_o,
    output logic              tst_en_o,
    output logic              tst_clr_o,
    output logic [CTRL_W-1:0] ctrl_rst_n_o,
    output logic              busy_o,
    output logic              ready_o,
    output logic              rate_err_o
);

    localparam int T_MAX_A = (T_CLR_US > T_SETTLE_US) ? T_CLR_US : T_SETTLE_US;
    localparam int T_MAX_B = (T_GAP_US > T_CTRL_US) ? T_GAP_US : T_CTRL_US;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int US_W    = $clog2(T_MAX + 1);

    seq_state_e      state_q;
    logic            tmr_load_q;
    logic [US_W-1:0] tmr_us_q;
    logic            tmr_done;
    logic [5:0]      map_code;
    logic            map_oor;
    logic [5:0]      code_q;
    logic            accept_start;
    logic            accept_stop;

    dphy_range_map #(
        .RATE_W   (RATE_W),
        .RATE_MIN (RATE_MIN),
        .RATE_MAX (RATE_MAX)
    ) u_map (
        .rate_i         (rate_mbps_i),
        .code_o         (map_code),
        .out_of_range_o (map_oor)
    );

    dphy_us_timer #(
        .CLKS_PER_US (CLKS_PER_US),
        .US_W        (US_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load_q),
        .us_i   (tmr_us_q),
        .done_o (tmr_done)
    );

    // Commands are only taken in idle; start has priority over stop.
    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign accept_stop  = (state_q == ST_IDLE) && stop_i && !start_i;

    assign tp_code_o = TEST_CODE;
    assign tp_data_o = {1'b0, code_q, 1'b0};

    // Sequence state and wait-timer loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tmr_load_q <= 1'b0;
            tmr_us_q   <= '0;
        end else begin
            tmr_load_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_start) begin
                        state_q    <= ST_CLR;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= US_W'(T_CLR_US);
                    end
                end
                ST_CLR: begin
                    if (tmr_done) begin
                        state_q    <= ST_SETTLE;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= US_W'(T_SETTLE_US);
                    end
                end
                ST_SETTLE: begin
                    if (tmr_done) state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (tp_done_i) begin
                        state_q    <= ST_SD_GAP;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= US_W'(T_GAP_US);
                    end
                end
                ST_SD_GAP: begin
                    if (tmr_done) begin
                        state_q    <= ST_RST_GAP;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= US_W'(T_GAP_US);
                    end
                end
                ST_RST_GAP: begin
                    if (tmr_done) begin
                        state_q    <= ST_CTRL_WAIT;
                        tmr_load_q <= 1'b1;
                        tmr_us_q   <= US_W'(T_CTRL_US);
                    end
                end
                ST_CTRL_WAIT: begin
                    if (tmr_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Captured configuration: lane setting, range code and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_cfg_o <= '0;
            code_q     <= '0;
            rate_err_o <= 1'b0;
        end else if (accept_start) begin
            lane_cfg_o <= LCFG_W'(lanes_i - LANE_W'(1));
            code_q     <= map_code;
            rate_err_o <= map_oor;
        end else if (accept_stop) begin
            lane_cfg_o <= '0;
        end
    end

    // Test-port idle levels and test clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst_clk_o <= 1'b0;
            tst_en_o  <= 1'b0;
            tst_clr_o <= 1'b0;
        end else if (accept_start) begin
            tst_clk_o <= 1'b1;
            tst_en_o  <= 1'b0;
            tst_clr_o <= 1'b1;
        end else if (state_q == ST_CLR && tmr_done) begin
            tst_clr_o <= 1'b0;
        end
    end

    // Test-port request: raised after settle, held until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_req_o <= 1'b0;
        end else if (state_q == ST_SETTLE && tmr_done) begin
            tp_req_o <= 1'b1;
        end else if (state_q == ST_XFER && tp_done_i) begin
            tp_req_o <= 1'b0;
        end
    end

    // PHY shutdown and reset: held low at start, released in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_shutdown_n_o <= 1'b0;
            phy_rst_n_o      <= 1'b0;
        end else if (accept_start) begin
            phy_shutdown_n_o <= 1'b0;
            phy_rst_n_o      <= 1'b0;
        end else if (state_q == ST_SD_GAP && tmr_done) begin
            phy_shutdown_n_o <= 1'b1;
        end else if (state_q == ST_RST_GAP && tmr_done) begin
            phy_rst_n_o      <= 1'b1;
        end
    end

    // Controller reset: released after PHY reset, asserted by stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rst_n_o <= '0;
        end else if (state_q == ST_RST_GAP && tmr_done) begin
            ctrl_rst_n_o <= '1;
        end else if (accept_stop) begin
            ctrl_rst_n_o <= '0;
        end
    end

    // Busy and ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            ready_o <= 1'b0;
        end else if (accept_start) begin
            busy_o  <= 1'b1;
            ready_o <= 1'b0;
        end else if (state_q == ST_CTRL_WAIT && tmr_done) begin
            busy_o  <= 1'b0;
            ready_o <= 1'b1;
        end else if (accept_stop) begin
            ready_o <= 1'b0;
        end
    end

    p_clr_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tst_clr_o |-> (!phy_rst_n_o && !phy_shutdown_n_o && busy_o));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_req_o && !tp_done_i) |=> (tp_req_o && $stable(tp_data_o)));

    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_req_o && tp_done_i) |=> !tp_req_o);

    p_code_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tp_req_o |-> (tp_data_o[0] == 1'b0 && tp_code_o == TEST_CODE));

    p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_n_o |-> phy_shutdown_n_o);

    p_ready_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ((&ctrl_rst_n_o) && phy_rst_n_o && !busy_o));

    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !start_i) |=>
            (lane_cfg_o == '0 && ctrl_rst_n_o == '0 && !ready_o));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(lane_cfg_o) && $stable(rate_err_o));

endmodule

// File: tb/dphy_rx_bringup_tb.sv
// Bench: runs full start sequences across every range boundary, checks
// timing windows, request contents, flags, stop and mid-sequence commands.
module dphy_rx_bringup_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int RATE_W     = 11;
    localparam int LANE_W     = 3;
    localparam int LCFG_W     = 2;
    localparam int CTRL_W     = 8;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              stop_i = 1'b0;
    logic [RATE_W-1:0] rate_mbps_i = '0;
    logic [LANE_W-1:0] lanes_i = 3'd1;
    logic              tp_done_i = 1'b0;
    logic              tp_req_o;
    logic [7:0]        tp_code_o;
    logic [7:0]        tp_data_o;
    logic [LCFG_W-1:0] lane_cfg_o;
    logic              phy_shutdown_n_o;
    logic              phy_rst_n_o;
    logic              tst_clk_o;
    logic              tst_en_o;
    logic              tst_clr_o;
    logic [CTRL_W-1:0] ctrl_rst_n_o;
    logic              busy_o;
    logic              ready_o;
    logic              rate_err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dphy_rx_bringup #(
        .CLKS_PER_US (CPU),
        .RATE_W      (RATE_W),
        .LANE_W      (LANE_W),
        .LCFG_W      (LCFG_W),
        .CTRL_W      (CTRL_W)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .stop_i           (stop_i),
        .rate_mbps_i      (rate_mbps_i),
        .lanes_i          (lanes_i),
        .tp_req_o         (tp_req_o),
        .tp_code_o        (tp_code_o),
        .tp_data_o        (tp_data_o),
        .tp_done_i        (tp_done_i),
        .lane_cfg_o       (lane_cfg_o),
        .phy_shutdown_n_o (phy_shutdown_n_o),
        .phy_rst_n_o      (phy_rst_n_o),
        .tst_clk_o        (tst_clk_o),
        .tst_en_o         (tst_en_o),
        .tst_clr_o        (tst_clr_o),
        .ctrl_rst_n_o     (ctrl_rst_n_o),
        .busy_o           (busy_o),
        .ready_o          (ready_o),
        .rate_err_o       (rate_err_o)
    );

    // Upper limits of the range list, from the requirements.
    function automatic int lim(input int i);
        int t[39] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249,
                      269, 299, 329, 359, 399, 449, 499, 549, 599, 649, 699,
                      749, 799, 849, 899, 949, 999, 1049, 1099, 1149, 1199,
                      1249, 1299, 1349, 1399, 1449, 1500};
        return t[i];
    endfunction

    function automatic int cod(input int i);
        int c[39] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22,
                      'h03, 'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06,
                      'h16, 'h07, 'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39,
                      'h0A, 'h1A, 'h2A, 'h3A, 'h0B, 'h1B, 'h2B, 'h3B, 'h0C,
                      'h1C, 'h2C, 'h3C};
        return c[i];
    endfunction

    function automatic int exp_data(input int rate);
        for (int i = 0; i < 39; i++) begin
            if (rate <= lim(i)) return cod(i) << 1;
        end
        return cod(38) << 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int us);
        chk(act >= us*CPU && act <= us*CPU + 4, req, act, us*CPU);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One full start sequence with engine latency lat; optional busy commands.
    task automatic run_seq(input int rate, input int lanes, input int lat, input bit poke);
        int t, clr_fall, req_t, done_t, sd_t, rst_t, rdy_t, req_cnt, w;
        int data_seen, code_seen;
        bit ctrl_ok, prev_req;
        clr_fall = -1; req_t = -1; done_t = -1; sd_t = -1; rst_t = -1; rdy_t = -1;
        req_cnt = 0; w = 0; data_seen = 0; code_seen = 0; ctrl_ok = 1'b0; prev_req = 1'b0;
        @(negedge clk);
        rate_mbps_i = RATE_W'(rate);
        lanes_i     = LANE_W'(lanes);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: values one clock after the accepted start
        chk(lane_cfg_o == LCFG_W'(lanes - 1), "R2 lane_cfg", int'(lane_cfg_o), lanes - 1);
        chk(!phy_shutdown_n_o && !phy_rst_n_o && tst_clk_o && !tst_en_o && tst_clr_o && busy_o,
            "R2 init levels",
            int'({phy_shutdown_n_o, phy_rst_n_o, tst_clk_o, tst_en_o, tst_clr_o, busy_o}),
            int'(6'b001011));
        t = 0;
        while (rdy_t < 0 && t < 2000) begin
            @(negedge clk);
            t++;
            tp_done_i = 1'b0;
            start_i   = 1'b0;
            stop_i    = 1'b0;
            if (poke && (t == 5 || t == 40)) begin
                start_i = 1'b1;
                stop_i  = 1'b1;
                lanes_i = LANE_W'((lanes % 4) + 1);
            end
            if (clr_fall < 0 && !tst_clr_o) clr_fall = t;
            if (tp_req_o && !prev_req) begin
                req_cnt++;
                if (req_t < 0) begin
                    req_t     = t;
                    data_seen = int'(tp_data_o);
                    code_seen = int'(tp_code_o);
                end
            end
            prev_req = tp_req_o;
            if (tp_req_o) begin
                if (w == lat) begin
                    tp_done_i = 1'b1;
                    done_t    = t;
                end
                w++;
            end
            if (sd_t < 0 && phy_shutdown_n_o) sd_t = t;
            if (rst_t < 0 && phy_rst_n_o) begin
                rst_t   = t;
                ctrl_ok = (ctrl_rst_n_o == '1);
            end
            if (ready_o) rdy_t = t;
        end
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk_win("R3 clear hold", clr_fall, 15);
        chk_win("R3 settle", req_t - clr_fall, 15);
        chk(req_cnt == 1, "R4 request count", req_cnt, 1);
        chk(code_seen == 'h44, "R4 test code", code_seen, 'h44);
        chk(data_seen == exp_data(rate), "R4 range data", data_seen, exp_data(rate));
        chk_win("R6 shutdown gap", sd_t - done_t, 5);
        chk_win("R6 reset gap", rst_t - sd_t, 5);
        chk(ctrl_ok, "R6 ctrl released with reset", int'(ctrl_ok), 1);
        chk_win("R7 ready wait", rdy_t - rst_t, 10);
        chk(!busy_o, "R7 busy falls", int'(busy_o), 0);
        chk(rate_err_o == (rate < 80 || rate > 1500), "R8 range flag",
            int'(rate_err_o), int'(rate < 80 || rate > 1500));
        if (poke) begin
            chk(lane_cfg_o == LCFG_W'(lanes - 1), "R10 lane_cfg after busy commands",
                int'(lane_cfg_o), lanes - 1);
            chk(ready_o, "R10 ready after busy commands", int'(ready_o), 1);
        end
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(lane_cfg_o == '0, "R9 lane_cfg", int'(lane_cfg_o), 0);
        chk(ctrl_rst_n_o == '0, "R9 ctrl reset", int'(ctrl_rst_n_o), 0);
        chk(!ready_o, "R9 ready", int'(ready_o), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(lane_cfg_o == '0 && !phy_shutdown_n_o && !phy_rst_n_o && ctrl_rst_n_o == '0,
            "R1 reset outputs", int'(ctrl_rst_n_o), 0);
        chk(!tst_clk_o && !tst_en_o && !tst_clr_o && !tp_req_o && !busy_o && !ready_o
            && !rate_err_o, "R1 reset flags",
            int'({tst_clk_o, tst_en_o, tst_clr_o, tp_req_o, busy_o, ready_o, rate_err_o}), 0);
        rst_n = 1'b1;
        n = 0;
        for (int i = 0; i < 39; i++) begin
            run_seq(lim(i), (n % 4) + 1, n % 4, (i % 9) == 4);
            n++;
            run_seq(lim(i) + 1, (n % 4) + 1, n % 4, 1'b0);
            n++;
            if (i % 7 == 3) do_stop();
        end
        run_seq(0, 1, 0, 1'b0);
        run_seq(79, 2, 1, 1'b0);
        run_seq(80, 3, 2, 1'b1);
        run_seq(1501, 4, 3, 1'b0);
        run_seq(2047, 4, 0, 1'b0);
        do_stop();
        do_stop();
        // R9: start and stop together, start wins
        @(negedge clk);
        rate_mbps_i = 11'd500;
        lanes_i     = 3'd3;
        start_i     = 1'b1;
        stop_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk(busy_o && lane_cfg_o == 2'd2, "R9 start wins over stop", int'(lane_cfg_o), 2);
        finish_run();
    end

endmodule